// File: doc/BRIEF.md
# Bezier Curve Vertex Evaluator

This block produces one vertex of a quadratic or cubic Bezier curve for each start request. The four control points and the curve type are sampled when a request is accepted. The curve parameter t is held inside the block. The first request of a curve sets t to zero. Every later request continues from the value of t left by the previous vertex.

The arithmetic uses a small pool of fixed-point multipliers and adders. A step controller feeds this pool from a set of working registers, so each unit computes a different partial product in each step. The cubic curve is worked in a nested form: the inner blend of P1 and P2 is formed first and then scaled by 3t(1-t). The quadratic curve is worked in expanded form.

After each vertex, a separate incrementer adds a programmable step to t and clamps the sum at 1.0. The vertex computed at t = 1.0 is marked as the end of the curve.

Top module: `bezier_vertex_eval`

## Requirements
- R1: With cubic=1, the output point is (1-t)^3*P0 + 3t(1-t)^2*P1 + 3t^2(1-t)*P2 + t^3*P3, computed separately for x and y. All coordinates are signed Q16.16. Every product is truncated back to Q16.16, so the result is exact whenever t has at most two fractional bits and the coordinates are whole numbers.
- R2: With cubic=0, the output point is (1-t)^2*P0 + 2t(1-t)*P1 + t^2*P2, with the same formats as R1.
- R3: The curve type and the control points are sampled on the clock edge that accepts start. For a quadratic curve, P3 has no effect on the result.
- R4: t is unsigned, 1.0 = 65536, and lies in [0, 65536]. A request accepted with first=1 uses t = 0. After each vertex, t becomes t + t_step, where t_step is unsigned Q0.16.
- R5: If t + t_step exceeds 1.0, t is clamped to 1.0. curve_end is high together with done exactly when the vertex was computed at t = 1.0. Further requests without first keep producing the t = 1.0 vertex.
- R6: busy goes high on the edge that accepts start. done goes high on the 5th rising edge after that edge for a cubic curve and on the 4th for a quadratic curve. While idle and without start, busy and done stay low.
- R7: done and curve_end are single-cycle pulses. pt_x and pt_y keep their value until the next done, whatever the inputs do.
- R8: start is ignored while busy. A start during busy does not change the result of the running vertex, the value of t, or the number of done pulses, whatever first, cubic or the points carry.
- R9: The reset is synchronous and active high. It returns the controller to idle and sets t, pt_x, pt_y, done and curve_end to zero, even in the middle of a vertex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one vertex |
| first | input | 1 | With start: begin a new curve at t = 0 |
| cubic | input | 1 | With start: 1 = cubic, 0 = quadratic |
| t_step | input | 16 | Parameter increment, unsigned Q0.16 |
| p0_x | input | 32 | P0 x, signed Q16.16 |
| p0_y | input | 32 | P0 y, signed Q16.16 |
| p1_x | input | 32 | P1 x, signed Q16.16 |
| p1_y | input | 32 | P1 y, signed Q16.16 |
| p2_x | input | 32 | P2 x, signed Q16.16 |
| p2_y | input | 32 | P2 y, signed Q16.16 |
| p3_x | input | 32 | P3 x, signed Q16.16 (cubic only) |
| p3_y | input | 32 | P3 y, signed Q16.16 (cubic only) |
| pt_x | output | 32 | Vertex x, signed Q16.16 |
| pt_y | output | 32 | Vertex y, signed Q16.16 |
| done | output | 1 | One-cycle pulse: vertex valid |
| curve_end | output | 1 | One-cycle pulse with done at t = 1.0 |
| busy | output | 1 | A vertex is being computed |

## Verification
Two cubic and two quadratic curves are each swept over t = 0, 0.25, 0.5, 0.75 and 1. The curves mix positive and negative coordinates, and each one places distinct values on every control point, so a swapped operand route or a wrong constant shows up in the interior vertices. The t = 0 and t = 1 vertices separate the endpoint terms from the blended ones. One quadratic curve carries a large P3 that must not leak into its result. A step of about 0.3 drives t past 1.0 to test the clamp and the end mark. A start pulse during a running vertex, carrying different points and type, tells a correctly ignored request apart from one that reloads state.

// File: rtl/bez_pkg.sv
package bez_pkg;
  // Controller steps; cubic walks C1,C2,MUL,ADD1,ADD2, quadratic walks Q1,MUL,ADD1,ADD2
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_C1,
    ST_C2,
    ST_Q1,
    ST_MUL,
    ST_ADD1,
    ST_ADD2
  } step_e;
endpackage

// File: rtl/bez_ctrl.sv
module bez_ctrl
  import bez_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  cubic,
  output step_e step,
  output logic  busy,
  output logic  launch,
  output logic  last
);
  step_e nxt;

  always_comb begin
    nxt = step;
    unique case (step)
      ST_IDLE:        if (start) nxt = cubic ? ST_C1 : ST_Q1;
      ST_C1:          nxt = ST_C2;
      ST_C2, ST_Q1:   nxt = ST_MUL;
      ST_MUL:         nxt = ST_ADD1;
      ST_ADD1:        nxt = ST_ADD2;
      ST_ADD2:        nxt = ST_IDLE;
      default:        nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_IDLE;
    else     step <= nxt;
  end

  assign busy   = (step != ST_IDLE);
  assign launch = (step == ST_IDLE) && start;
  assign last   = (step == ST_ADD2);
endmodule

// File: rtl/bez_mul_pool.sv
module bez_mul_pool #(
  parameter int W = 32,
  parameter int F = 16,
  parameter int N = 7
) (
  input  logic signed [W-1:0] opa  [N],
  input  logic signed [W-1:0] opb  [N],
  output logic signed [W-1:0] prod [N]
);
  localparam int PW = 2 * W;

  for (genvar i = 0; i < N; i++) begin : g_mul
    logic signed [PW-1:0] full;
    assign full    = opa[i] * opb[i];
    // truncate back to the coordinate format
    assign prod[i] = full[F+W-1:F];
  end
endmodule

// File: rtl/bez_add_pool.sv
module bez_add_pool #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic signed [W-1:0] opa [N],
  input  logic signed [W-1:0] opb [N],
  output logic signed [W-1:0] sum [N]
);
  for (genvar i = 0; i < N; i++) begin : g_add
    assign sum[i] = opa[i] + opb[i];
  end
endmodule

// File: rtl/bezier_vertex_eval.sv
module bezier_vertex_eval
  import bez_pkg::*;
#(
  parameter int W    = 32,
  parameter int F    = 16,
  parameter int NMUL = 7,
  parameter int NADD = 2,
  parameter int NWR  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                first,
  input  logic                cubic,
  input  logic [F-1:0]        t_step,
  input  logic signed [W-1:0] p0_x,
  input  logic signed [W-1:0] p0_y,
  input  logic signed [W-1:0] p1_x,
  input  logic signed [W-1:0] p1_y,
  input  logic signed [W-1:0] p2_x,
  input  logic signed [W-1:0] p2_y,
  input  logic signed [W-1:0] p3_x,
  input  logic signed [W-1:0] p3_y,
  output logic signed [W-1:0] pt_x,
  output logic signed [W-1:0] pt_y,
  output logic                done,
  output logic                curve_end,
  output logic                busy
);
  localparam int NPT = 4;
  localparam logic signed [W-1:0] ONE = {{(W-F-1){1'b0}}, 1'b1, {F{1'b0}}};
  localparam logic signed [W-1:0] K2  = {{(W-F-2){1'b0}}, 2'b10, {F{1'b0}}};
  localparam logic signed [W-1:0] K3  = {{(W-F-2){1'b0}}, 2'b11, {F{1'b0}}};

  step_e step;
  logic  launch, last;

  bez_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cubic(cubic),
    .step(step), .busy(busy), .launch(launch), .last(last)
  );

  // latched request
  logic signed [W-1:0] px [NPT];
  logic signed [W-1:0] py [NPT];
  logic                cub_q;
  logic [F-1:0]        stp_q;
  logic signed [W-1:0] t_q;

  // working registers and unit operands
  logic signed [W-1:0] wr   [NWR];
  logic signed [W-1:0] ma   [NMUL];
  logic signed [W-1:0] mb   [NMUL];
  logic signed [W-1:0] prod [NMUL];
  logic signed [W-1:0] aa   [NADD];
  logic signed [W-1:0] ab   [NADD];
  logic signed [W-1:0] sum  [NADD];

  logic signed [W-1:0] u, far_x, far_y, t_sum, t_nxt;

  assign u     = ONE - t_q;
  assign far_x = cub_q ? px[3] : px[2];
  assign far_y = cub_q ? py[3] : py[2];

  // parameter advance: the extra adder, clamped at 1.0
  assign t_sum = t_q + $signed({{(W-F){1'b0}}, stp_q});
  assign t_nxt = (t_sum > ONE) ? ONE : t_sum;

  // operand routing per step
  always_comb begin
    for (int i = 0; i < NMUL; i++) begin
      ma[i] = '0;
      mb[i] = '0;
    end
    for (int i = 0; i < NADD; i++) begin
      aa[i] = '0;
      ab[i] = '0;
    end
    unique case (step)
      ST_C1: begin
        ma[0] = u;     mb[0] = u;       // (1-t)^2
        ma[1] = t_q;   mb[1] = t_q;     // t^2
        ma[2] = K3;    mb[2] = t_q;     // 3t
        ma[3] = u;     mb[3] = px[1];
        ma[4] = t_q;   mb[4] = px[2];
        ma[5] = u;     mb[5] = py[1];
        ma[6] = t_q;   mb[6] = py[2];
      end
      ST_C2: begin
        ma[0] = wr[0]; mb[0] = u;       // (1-t)^3
        ma[1] = wr[1]; mb[1] = t_q;     // t^3
        ma[2] = wr[2]; mb[2] = u;       // 3t(1-t)
        aa[0] = wr[3]; ab[0] = wr[4];   // inner x
        aa[1] = wr[5]; ab[1] = wr[6];   // inner y
      end
      ST_Q1: begin
        ma[0] = u;     mb[0] = u;       // (1-t)^2
        ma[1] = t_q;   mb[1] = t_q;     // t^2
        ma[2] = t_q;   mb[2] = u;       // t(1-t)
        ma[3] = K2;    mb[3] = px[1];
        ma[4] = K2;    mb[4] = py[1];
      end
      ST_MUL: begin
        ma[0] = wr[0]; mb[0] = px[0];
        ma[1] = wr[0]; mb[1] = py[0];
        ma[2] = wr[2]; mb[2] = wr[3];
        ma[3] = wr[2]; mb[3] = wr[5];
        ma[4] = wr[1]; mb[4] = far_x;
        ma[5] = wr[1]; mb[5] = far_y;
      end
      ST_ADD1: begin
        aa[0] = wr[4]; ab[0] = wr[3];
        aa[1] = wr[6]; ab[1] = wr[5];
      end
      ST_ADD2: begin
        aa[0] = wr[4]; ab[0] = wr[7];
        aa[1] = wr[6]; ab[1] = wr[0];
      end
      default: ;
    endcase
  end

  bez_mul_pool #(.W(W), .F(F), .N(NMUL)) u_mul (.opa(ma), .opb(mb), .prod(prod));
  bez_add_pool #(.W(W), .N(NADD))        u_add (.opa(aa), .opb(ab), .sum(sum));

  // working register writes
  always_ff @(posedge clk) begin
    unique case (step)
      ST_C1: for (int i = 0; i < 7; i++) wr[i] <= prod[i];
      ST_C2: begin
        wr[0] <= prod[0]; wr[1] <= prod[1]; wr[2] <= prod[2];
        wr[3] <= sum[0];  wr[5] <= sum[1];
      end
      ST_Q1: begin
        wr[0] <= prod[0]; wr[1] <= prod[1]; wr[2] <= prod[2];
        wr[3] <= prod[3]; wr[5] <= prod[4];
      end
      ST_MUL: begin
        wr[4] <= prod[0]; wr[6] <= prod[1]; wr[3] <= prod[2];
        wr[5] <= prod[3]; wr[7] <= prod[4]; wr[0] <= prod[5];
      end
      ST_ADD1: begin
        wr[4] <= sum[0]; wr[6] <= sum[1];
      end
      default: ;
    endcase
  end

  // request capture, parameter and outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      t_q       <= '0;
      pt_x      <= '0;
      pt_y      <= '0;
      done      <= 1'b0;
      curve_end <= 1'b0;
    end else begin
      done      <= 1'b0;
      curve_end <= 1'b0;
      if (launch) begin
        px[0] <= p0_x; px[1] <= p1_x; px[2] <= p2_x; px[3] <= p3_x;
        py[0] <= p0_y; py[1] <= p1_y; py[2] <= p2_y; py[3] <= p3_y;
        cub_q <= cubic;
        stp_q <= t_step;
        if (first) t_q <= '0;
      end
      if (last) begin
        pt_x      <= sum[0];
        pt_y      <= sum[1];
        done      <= 1'b1;
        curve_end <= (t_q == ONE);
        t_q       <= t_nxt;
      end
    end
  end
endmodule

// File: rtl/bez_eval_chk.sv
module bez_eval_chk #(
  parameter int W = 32,
  parameter int F = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                curve_end,
  input logic signed [W-1:0] t_cur
);
  localparam logic signed [W-1:0] ONE = {{(W-F-1){1'b0}}, 1'b1, {F{1'b0}}};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    curve_end |-> done); // R5

  AST_T_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!t_cur[W-1] && t_cur <= ONE)); // R4

  AST_T_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done || $stable(t_cur))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!busy && !done)); // R6

  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R6
endmodule

bind bezier_vertex_eval bez_eval_chk #(.W(W), .F(F)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .curve_end(curve_end), .t_cur(t_q)
);

// File: tb/bezier_vertex_eval_tb_top.sv
module bezier_vertex_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int F = 16;
  localparam int QSTEP = 16384;  // 0.25
  // each row: cubic, p0x, p0y, p1x, p1y, p2x, p2y, p3x, p3y (whole numbers)
  localparam int VEC [4][9] = '{
    '{1,   0,   0,  10,  20,  30, -20,  40,   0},
    '{1,  -8,   5, 100,  -3, -50,  60,   7,  -9},
    '{0,   0,   0,  16,  32,  32,   0, 999, 999},
    '{0, -20, -40,   4, 100,  60, -12,   0,   0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, first = 1'b0, cubic = 1'b0;
  logic [F-1:0] t_step = '0;
  logic signed [W-1:0] p0_x = '0, p0_y = '0, p1_x = '0, p1_y = '0;
  logic signed [W-1:0] p2_x = '0, p2_y = '0, p3_x = '0, p3_y = '0;
  logic signed [W-1:0] pt_x, pt_y;
  logic done, curve_end, busy;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bezier_vertex_eval dut_i (
    .clk(clk), .rst(rst), .start(start), .first(first), .cubic(cubic),
    .t_step(t_step),
    .p0_x(p0_x), .p0_y(p0_y), .p1_x(p1_x), .p1_y(p1_y),
    .p2_x(p2_x), .p2_y(p2_y), .p3_x(p3_x), .p3_y(p3_y),
    .pt_x(pt_x), .pt_y(pt_y), .done(done), .curve_end(curve_end), .busy(busy)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected Q16.16 coordinate at t = k/4
  function automatic longint expect_at(input bit cub, input int k,
                                       input int c0, input int c1, input int c2, input int c3);
    longint j = 4 - k;
    if (cub)
      return (j*j*j*c0 + 3*k*j*j*c1 + 3*k*k*j*c2 + longint'(k)*k*k*c3) * 1024;
    return (j*j*c0 + 2*k*j*c1 + longint'(k)*k*c2) * 4096;
  endfunction

  task automatic set_pts(input int r);
    cubic = VEC[r][0][0];
    p0_x = VEC[r][1] <<< 16; p0_y = VEC[r][2] <<< 16;
    p1_x = VEC[r][3] <<< 16; p1_y = VEC[r][4] <<< 16;
    p2_x = VEC[r][5] <<< 16; p2_y = VEC[r][6] <<< 16;
    p3_x = VEC[r][7] <<< 16; p3_y = VEC[r][8] <<< 16;
  endtask

  // one request; lat = rising edges from the accepting edge to done
  task automatic run_vertex(input bit fst, output int lat);
    @(negedge clk); start = 1'b1; first = fst;
    @(negedge clk); start = 1'b0; first = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin
      @(negedge clk); lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, cnt, extra;
    longint hx, hy;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 busy after reset", busy, 0);
    check("R9 done after reset", done, 0);
    check("R9 curve_end after reset", curve_end, 0);
    check("R9 pt_x after reset", pt_x, 0);

    // R1/R2/R3/R5/R6 table walk
    for (int r = 0; r < 4; r++) begin
      set_pts(r);
      t_step = QSTEP;
      for (int k = 0; k <= 4; k++) begin
        run_vertex(k == 0, lat);
        check(VEC[r][0] != 0 ? "R1 cubic x" : "R2 R3 quad x", pt_x,
              expect_at(VEC[r][0][0], k, VEC[r][1], VEC[r][3], VEC[r][5], VEC[r][7]));
        check(VEC[r][0] != 0 ? "R1 cubic y" : "R2 R3 quad y", pt_y,
              expect_at(VEC[r][0][0], k, VEC[r][2], VEC[r][4], VEC[r][6], VEC[r][8]));
        check("R5 curve_end", curve_end, (k == 4) ? 1 : 0);
        if (k == 0) check("R6 latency", lat, (VEC[r][0] != 0) ? 5 : 4);
      end
      @(negedge clk);
      check("R7 done pulse", done, 0);
    end

    // R7 outputs hold while inputs change
    hx = pt_x; hy = pt_y;
    set_pts(1);
    repeat (3) @(negedge clk);
    check("R7 hold x", pt_x, hx);
    check("R7 hold y", pt_y, hy);

    // R4/R5 clamp with step of about 0.3
    set_pts(0);
    t_step = 16'd19661;
    for (int k = 0; k < 4; k++) begin
      run_vertex(k == 0, lat);
      if (k == 0) check("R4 first at t=0", pt_x, longint'(VEC[0][1]) <<< 16);
      check("R5 no end before clamp", curve_end, 0);
    end
    run_vertex(1'b0, lat);
    check("R5 clamped end flag", curve_end, 1);
    check("R5 clamped x = P3", pt_x, longint'(VEC[0][7]) <<< 16);
    check("R5 clamped y = P3", pt_y, longint'(VEC[0][8]) <<< 16);
    run_vertex(1'b0, lat);
    check("R5 stays at end", curve_end, 1);
    check("R5 stays at P3", pt_x, longint'(VEC[0][7]) <<< 16);

    // R8 start during busy is ignored; R3 points sampled at accept
    @(negedge clk);
    set_pts(0); t_step = QSTEP; start = 1'b1; first = 1'b1;
    @(negedge clk); start = 1'b0; first = 1'b0;
    set_pts(3);
    @(negedge clk); start = 1'b1; first = 1'b1;
    @(negedge clk); start = 1'b0; first = 1'b0;
    cnt = 0;
    while (!done && cnt < 50) begin
      @(negedge clk); cnt++;
    end
    check("R8 R3 running result x", pt_x, longint'(VEC[0][1]) <<< 16);
    check("R8 R3 running result y", pt_y, longint'(VEC[0][2]) <<< 16);
    extra = 0;
    repeat (8) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check("R8 no second vertex", extra, 0);
    set_pts(0);
    run_vertex(1'b0, lat);
    check("R8 t not reloaded x", pt_x, expect_at(1'b1, 1, VEC[0][1], VEC[0][3], VEC[0][5], VEC[0][7]));
    check("R4 step advance y", pt_y, expect_at(1'b1, 1, VEC[0][2], VEC[0][4], VEC[0][6], VEC[0][8]));

    // R9 reset mid-vertex clears controller and t
    @(negedge clk); start = 1'b1; first = 1'b0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 busy cleared mid-run", busy, 0);
    check("R9 pt cleared mid-run", pt_x, 0);
    run_vertex(1'b0, lat);
    check("R9 t cleared to 0", pt_x, longint'(VEC[0][1]) <<< 16);
    check("R9 t cleared y", pt_y, longint'(VEC[0][2]) <<< 16);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule